// File: doc/BRIEF.md
# Level-1 Latency Pipeline and Event Buffer

This block sits on a detector readout card. On every beam crossing (about 106 ns apart) it stores the card's 96-bit hit pattern in a circular delay pipeline 64 crossings deep. That depth covers the time the level-1 trigger needs to decide. The crossing strobe `xing_valid` marks each crossing. A free-running 16-bit beam-clock counter numbers the crossings.

A level-1 accept comes in together with a crossing. The block then takes the pattern that was written a programmable number of crossings earlier and tags it with the beam-clock number of the accepting crossing. It pushes the two into a five-event derandomizing buffer. The crate controller drains the buffer one event at a time. After a read request the block sends the event as six 16-bit pattern words followed by one stamp word, with a data-valid strobe. The controller compares the stamp with its own crossing count, which exposes readout misalignment.

When the buffer holds five events the block raises a halt/busy line. An accept that arrives while the buffer is full is dropped and counted. The readout is a two-state machine:
- `RD_IDLE` waits for a request. Its transition *start* (request with the buffer not empty) leads to `RD_SEND`.
- `RD_SEND` walks through the words. Its transition *advance* stays in `RD_SEND` for the next word. Its transition *finish* happens on the stamp word: it pops the event and returns to `RD_IDLE`.

Top module: `l1_event_buffer`

## Requirements
- R1: Each cycle with `xing_valid` high writes `pattern_in` into the pipeline and advances the 16-bit beam-clock counter by one. The first crossing after reset carries stamp 0.
- R2: When `l1_accept` and `xing_valid` are high in the same cycle, the captured pattern is the one written `latency` crossings before that crossing. `latency` runs from 1 to 64, and 64 is written as 7'd64. The captured stamp is the beam-clock number of the accepting crossing.
- R3: `l1_accept` in a cycle without `xing_valid` is ignored: no event enters the buffer.
- R4: The buffer holds up to five events and delivers them in arrival order.
- R5: `halt` is high exactly while five events are buffered. It falls once an event has been read out.
- R6: An accept that arrives while the buffer is full is dropped. The buffered events are unchanged, and `ovf_count` (8 bits, wrapping) goes up by one.
- R7: A read request sampled in `RD_IDLE` with a non-empty buffer gives, from the next cycle, seven consecutive `rd_valid` cycles. Word k (k = 0 to 5) is pattern bits [16k+15:16k], and word 6 is the stamp.
- R8: A read request with the buffer empty gives no `rd_valid`. A read request made during a transfer is ignored.
- R9: After reset `halt`, `rd_valid` and `ovf_count` are zero and the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xing_valid | input | 1 | Beam-crossing strobe, one cycle per crossing |
| pattern_in | input | 96 | Hit pattern of the current crossing |
| l1_accept | input | 1 | Level-1 accept, qualified by `xing_valid` |
| latency | input | 7 | Pipeline tap in crossings, 1 to 64 |
| rd_req | input | 1 | Request to read the oldest buffered event |
| rd_data | output | 16 | Readout word |
| rd_valid | output | 1 | Data-valid strobe for `rd_data` |
| halt | output | 1 | Buffer full, busy indication |
| ovf_count | output | 8 | Count of accepts dropped while full |

## Verification
The bench sets the tap to 1 and to 64, the two ends of the range. An address off by one, or a 64 that wraps to the wrong slot, returns the pattern of a neighbouring crossing. It fills the buffer to five and sends a sixth accept. A design that overwrote an entry or dropped silently would then show a wrong event during readout or an unchanged `ovf_count`. It also sends an accept without a crossing, a request on an empty buffer, and a request in the middle of a transfer. A loose qualifier would leave a stray event in the buffer. A missing empty check would strobe garbage. A request that restarted the machine would repeat words or skip an event.

// File: rtl/l1eb_pkg.sv
package l1eb_pkg;
    typedef enum logic {
        RD_IDLE,
        RD_SEND
    } rd_state_t;
endpackage

// File: rtl/l1eb_pipeline.sv
module l1eb_pipeline #(
    parameter int PAT_W   = 96,
    parameter int DEPTH   = 64,
    parameter int STAMP_W = 16,
    localparam int AW     = $clog2(DEPTH),
    localparam int LAT_W  = AW + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [PAT_W-1:0]   wr_pat,
    input  logic [LAT_W-1:0]   lat,
    output logic [PAT_W-1:0]   tap_pat,
    output logic [STAMP_W-1:0] stamp
);
    // DEPTH must be a power of two: the ring index wraps naturally.
    logic [PAT_W-1:0] ring [DEPTH];
    logic [AW-1:0]    wp;
    logic [AW-1:0]    rd_addr;

    // A tap of DEPTH truncates to zero and reads the slot about to be overwritten.
    assign rd_addr = wp - lat[AW-1:0];
    assign tap_pat = ring[rd_addr];

    always_ff @(posedge clk) begin
        if (wr_en) ring[wp] <= wr_pat;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            stamp <= '0;
        end else if (wr_en) begin
            wp    <= wp + 1'b1;
            stamp <= stamp + 1'b1;
        end
    end
endmodule

// File: rtl/l1eb_event_fifo.sv
module l1eb_event_fifo #(
    parameter int ENT_W  = 112,
    parameter int EVENTS = 5,
    parameter int OVF_W  = 8,
    localparam int PW    = (EVENTS > 1) ? $clog2(EVENTS) : 1,
    localparam int CW    = $clog2(EVENTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [ENT_W-1:0] push_data,
    input  logic             pop,
    output logic [ENT_W-1:0] head,
    output logic [CW-1:0]    occ,
    output logic             full,
    output logic             empty,
    output logic [OVF_W-1:0] ovf_count
);
    logic [ENT_W-1:0] slots [EVENTS];
    logic [PW-1:0]    wr_ptr;
    logic [PW-1:0]    rd_ptr;
    logic             do_push;
    logic             do_pop;

    assign full    = (occ == CW'(EVENTS));
    assign empty   = (occ == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = slots[rd_ptr];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(EVENTS - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) slots[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr    <= '0;
            rd_ptr    <= '0;
            occ       <= '0;
            ovf_count <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            unique case ({do_push, do_pop})
                2'b10:   occ <= occ + 1'b1;
                2'b01:   occ <= occ - 1'b1;
                default: occ <= occ;
            endcase
            if (push && full) ovf_count <= ovf_count + 1'b1;
        end
    end
endmodule

// File: rtl/l1eb_readout_fsm.sv
module l1eb_readout_fsm
    import l1eb_pkg::*;
#(
    parameter int PAT_W   = 96,
    parameter int WORD_W  = 16,
    localparam int NWORDS = PAT_W / WORD_W,
    localparam int IW     = $clog2(NWORDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic              empty,
    input  logic [PAT_W-1:0]  head_pat,
    input  logic [WORD_W-1:0] head_stamp,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              pop
);
    rd_state_t         state;
    logic [IW-1:0]     idx;
    logic [WORD_W-1:0] words [NWORDS + 1];

    for (genvar g = 0; g < NWORDS; g++) begin : g_slice
        assign words[g] = head_pat[g*WORD_W +: WORD_W];
    end
    assign words[NWORDS] = head_stamp;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RD_IDLE;
            idx   <= '0;
        end else begin
            unique case (state)
                RD_IDLE: begin
                    if (rd_req && !empty) begin   // start
                        state <= RD_SEND;
                        idx   <= '0;
                    end
                end
                RD_SEND: begin
                    if (idx == IW'(NWORDS)) begin // finish
                        state <= RD_IDLE;
                        idx   <= '0;
                    end else begin                // advance
                        idx <= idx + 1'b1;
                    end
                end
                default: state <= RD_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        rd_valid = 1'b0;
        pop      = 1'b0;
        rd_data  = '0;
        unique case (state)
            RD_IDLE: ;
            RD_SEND: begin
                rd_valid = 1'b1;
                rd_data  = words[idx];
                pop      = (idx == IW'(NWORDS));
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/l1_event_buffer.sv
module l1_event_buffer #(
    parameter int PAT_W   = 96,
    parameter int DEPTH   = 64,
    parameter int EVENTS  = 5,
    parameter int WORD_W  = 16,
    parameter int OVF_W   = 8,
    localparam int LAT_W  = $clog2(DEPTH) + 1,
    localparam int ENT_W  = PAT_W + WORD_W,
    localparam int CW     = $clog2(EVENTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xing_valid,
    input  logic [PAT_W-1:0]  pattern_in,
    input  logic              l1_accept,
    input  logic [LAT_W-1:0]  latency,
    input  logic              rd_req,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              halt
    ,
    output logic [OVF_W-1:0]  ovf_count
);
    logic [PAT_W-1:0]  tap_pat;
    logic [WORD_W-1:0] stamp;
    logic [ENT_W-1:0]  head;
    logic [CW-1:0]     occ;
    logic              empty;
    logic              pop;
    logic              capture;

    assign capture = l1_accept && xing_valid;

    l1eb_pipeline #(.PAT_W(PAT_W), .DEPTH(DEPTH), .STAMP_W(WORD_W)) u_pipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (xing_valid),
        .wr_pat  (pattern_in),
        .lat     (latency),
        .tap_pat (tap_pat),
        .stamp   (stamp)
    );

    l1eb_event_fifo #(.ENT_W(ENT_W), .EVENTS(EVENTS), .OVF_W(OVF_W)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (capture),
        .push_data ({stamp, tap_pat}),
        .pop       (pop),
        .head      (head),
        .occ       (occ),
        .full      (halt),
        .empty     (empty),
        .ovf_count (ovf_count)
    );

    l1eb_readout_fsm #(.PAT_W(PAT_W), .WORD_W(WORD_W)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_req     (rd_req),
        .empty      (empty),
        .head_pat   (head[PAT_W-1:0]),
        .head_stamp (head[ENT_W-1:PAT_W]),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid),
        .pop        (pop)
    );
endmodule

// File: rtl/l1eb_chk.sv
module l1eb_chk #(
    parameter int EVENTS = 5,
    parameter int NWORDS = 6,
    parameter int CW     = 3,
    parameter int OVF_W  = 8,
    parameter int STW    = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             xing_valid,
    input logic             l1_accept,
    input logic             halt,
    input logic             rd_valid,
    input logic [CW-1:0]    occ,
    input logic [OVF_W-1:0] ovf_count,
    input logic [STW-1:0]   stamp
);
    logic [3:0] run;

    always_ff @(posedge clk) begin
        if (!rst_n)        run <= '0;
        else if (rd_valid) run <= run + 1'b1;
        else               run <= '0;
    end

    // R1
    stamp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xing_valid |=> stamp == $past(stamp) + 1'b1);

    // R4
    occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CW'(EVENTS));

    // R5
    halt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == CW'(EVENTS - 1) && xing_valid && l1_accept && !rd_valid) |=> halt);

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && xing_valid && l1_accept) |=> ovf_count == $past(ovf_count) + 1'b1);

    // R7
    word_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_valid && run != 4'd0) |-> run == 4'(NWORDS + 1));

    // R8
    valid_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> occ != '0);
endmodule

bind l1_event_buffer l1eb_chk #(
    .EVENTS (EVENTS),
    .NWORDS (PAT_W / WORD_W),
    .CW     (CW),
    .OVF_W  (OVF_W),
    .STW    (WORD_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .xing_valid (xing_valid),
    .l1_accept  (l1_accept),
    .halt       (halt),
    .rd_valid   (rd_valid),
    .occ        (occ),
    .ovf_count  (ovf_count),
    .stamp      (stamp)
);

// File: tb/sim_l1_event_buffer.sv
`timescale 1ns/1ps
module sim_l1_event_buffer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xing_valid = 1'b0;
    logic [95:0] pattern_in = '0;
    logic        l1_accept = 1'b0;
    logic [6:0]  latency = 7'd10;
    logic        rd_req = 1'b0;
    logic [15:0] rd_data;
    logic        rd_valid;
    logic        halt;
    logic [7:0]  ovf_count;

    int checks = 0;
    int fails  = 0;
    int n      = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    l1_event_buffer u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .xing_valid (xing_valid),
        .pattern_in (pattern_in),
        .l1_accept  (l1_accept),
        .latency    (latency),
        .rd_req     (rd_req),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid),
        .halt       (halt),
        .ovf_count  (ovf_count)
    );

    function automatic logic [95:0] pat(input int k);
        logic [31:0] u;
        u = k;
        return {u * 32'h9E37_79B1, u ^ 32'h5A5A_C3C3, u + 32'h0001_0000};
    endfunction

    task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic xing(input bit acc);
        @(negedge clk);
        xing_valid = 1'b1;
        l1_accept  = acc;
        pattern_in = pat(n);
        @(negedge clk);
        xing_valid = 1'b0;
        l1_accept  = 1'b0;
        n++;
    endtask

    task automatic read_event(input logic [95:0] ep, input int es, input string req, input bit poke);
        logic [15:0] w;
        @(negedge clk);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        for (int k = 0; k < 7; k++) begin
            w = (k < 6) ? ep[16*k +: 16] : es[15:0];
            check_eq({req, "/R7 valid"}, {31'd0, rd_valid}, 32'd1);
            check_eq({req, "/R7 word"}, {16'd0, rd_data}, {16'd0, w});
            rd_req = (poke && k == 3);
            @(negedge clk);
        end
        rd_req = 1'b0;
        check_eq({req, "/R7 end"}, {31'd0, rd_valid}, 32'd0);
    endtask

    task automatic read_empty(input string req);
        @(negedge clk);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        check_eq(req, {31'd0, rd_valid}, 32'd0);
        @(negedge clk);
        check_eq(req, {31'd0, rd_valid}, 32'd0);
    endtask

    task automatic t_reset;
        check_eq("R9 halt", {31'd0, halt}, 32'd0);
        check_eq("R9 rd_valid", {31'd0, rd_valid}, 32'd0);
        check_eq("R9 ovf", {24'd0, ovf_count}, 32'd0);
        read_empty("R8 empty after reset");
    endtask

    task automatic t_single;
        int s;
        latency = 7'd10;
        s = n;
        xing(1'b1);
        read_event(pat(s - 10), s, "R2 tap10 R1", 1'b0);
    endtask

    task automatic t_taps;
        int s1;
        int s2;
        latency = 7'd1;
        s1 = n;
        xing(1'b1);
        latency = 7'd64;
        s2 = n;
        xing(1'b1);
        read_event(pat(s1 - 1), s1, "R4 R2 tap1", 1'b0);
        read_event(pat(s2 - 64), s2, "R2 tap64", 1'b0);
    endtask

    task automatic t_ignore;
        @(negedge clk);
        l1_accept = 1'b1;
        @(negedge clk);
        l1_accept = 1'b0;
        read_empty("R3 accept without crossing");
    endtask

    task automatic t_full;
        int st [5];
        latency = 7'd5;
        for (int i = 0; i < 5; i++) begin
            st[i] = n;
            xing(1'b1);
        end
        check_eq("R5 halt when five", {31'd0, halt}, 32'd1);
        xing(1'b1);
        check_eq("R6 ovf count", {24'd0, ovf_count}, 32'd1);
        check_eq("R6 halt stays", {31'd0, halt}, 32'd1);
        read_event(pat(st[0] - 5), st[0], "R4 R8 ev0 poke", 1'b1);
        check_eq("R5 halt falls", {31'd0, halt}, 32'd0);
        for (int i = 1; i < 5; i++) begin
            read_event(pat(st[i] - 5), st[i], "R6 R4 ev", 1'b0);
        end
        read_empty("R6 R8 dropped event absent");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        for (int i = 0; i < 70; i++) xing(1'b0);
        t_single();
        t_taps();
        t_ignore();
        t_full();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule